// File: doc/BRIEF.md
# Five-Level Inverter Gate Mode Selector

This block turns one high-frequency PWM bit and three comparator bits into the six gate commands of a single-phase five-level inverter. Two of the gates drive the dual-buck pair that stacks the two DC-link capacitors. The other four drive the full bridge, which switches only at grid frequency. The capacitor-balance bit picks which buck switch chops. The region bit, set when half the bus voltage exceeds the grid magnitude, picks two things: whether the idle buck switch is held off or held on, and which way the balance choice runs. The polarity bit picks the bridge diagonal. A dead interval with all four bridge gates off is placed at every polarity change.

The three comparator bits each pass through a two-flop synchroniser. They change the active switch assignment only on a rising edge of the PWM bit, which is taken as the start of a PWM period. This prevents runt pulses. The PWM bit is assumed synchronous to the clock. All gate outputs are registered. The block also reports which of the eight operating modes is active.

Top module: `five_lvl_gate_sel`

## Requirements
- R1: While the synchronous reset `rst` is high, the block drives all six gates to 0 and drives `mode_code` to 2 (mode 3) on the next clock edge.
- R2: In the low region (`low_amp_in`=1) with `cap_hi_in`=1, `buck_a` equals `pwm_in` delayed by one clock, and `buck_b` is 0.
- R3: In the low region with `cap_hi_in`=0, `buck_b` equals `pwm_in` delayed by one clock, and `buck_a` is 0.
- R4: In the high region (`low_amp_in`=0) with `cap_hi_in`=1, `buck_b` equals `pwm_in` delayed by one clock, and `buck_a` is held at 1.
- R5: In the high region with `cap_hi_in`=0, `buck_a` equals `pwm_in` delayed by one clock, and `buck_b` is held at 1.
- R6: When the bridge is settled, positive polarity (`pol_pos_in`=1) turns on `brg_pos_a` and `brg_pos_b` with both negative gates off. Negative polarity reverses this.
- R7: A polarity change that takes effect at a clock edge turns off all four bridge gates for `dead_cycles`+1 clocks, starting at that edge. The new diagonal turns on at the edge after that.
- R8: A change on `cap_hi_in`, `low_amp_in` or `pol_pos_in` has no effect on the gates or the mode until the first clock edge at which `pwm_in` is 1 after being 0 at the previous edge. The bit must also have been held for two clock edges before that edge.
- R9: `mode_code` holds the mode number minus one. The number is 1 to 4 for positive polarity and 5 to 8 for negative. Within each half, the modes are ordered: only `buck_a` on, only `buck_b` on, both off, both on.
- R10: A positive bridge gate and a negative bridge gate are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm_in | input | 1 | High-frequency PWM bit, synchronous to clk |
| cap_hi_in | input | 1 | 1 when the upper capacitor voltage exceeds the lower |
| low_amp_in | input | 1 | 1 when half the bus voltage exceeds the grid magnitude |
| pol_pos_in | input | 1 | 1 for positive grid half-cycle |
| dead_cycles | input | DT_W | Bridge dead time, in clocks minus one |
| buck_a | output | 1 | Upper buck switch gate |
| buck_b | output | 1 | Lower buck switch gate |
| brg_pos_a | output | 1 | Positive diagonal, first switch |
| brg_pos_b | output | 1 | Positive diagonal, second switch |
| brg_neg_a | output | 1 | Negative diagonal, first switch |
| brg_neg_b | output | 1 | Negative diagonal, second switch |
| mode_code | output | 3 | Active mode number minus one |

## Verification
The bench drives each of the four region and balance combinations and checks which buck switch chops and what level the other holds. A design with the balance choice not inverted between regions would chop the wrong switch and drain the lower capacitor. Comparator changes are applied in the middle of a PWM period to confirm that the assignment waits for the next rising edge; a design that updated at once would cut a gate pulse short. Polarity flips are checked with both a long and a zero dead time. An off-by-one dead counter, or a diagonal turned on one cycle early, would show as a wrong bridge level on a specific clock.

// File: rtl/five_lvl_gate_sel.sv
module five_lvl_gate_sel #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pwm_in,
  input  logic            cap_hi_in,
  input  logic            low_amp_in,
  input  logic            pol_pos_in,
  input  logic [DT_W-1:0] dead_cycles,
  output logic            buck_a,
  output logic            buck_b,
  output logic            brg_pos_a,
  output logic            brg_pos_b,
  output logic            brg_neg_a,
  output logic            brg_neg_b,
  output logic [2:0]      mode_code
);

  logic [2:0] s1, s2;
  logic       pwm_prev;
  logic       act_cap, act_low, act_pol;
  logic       mode_pol;
  logic       dead_q, br_pol;
  logic [DT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 3'b111;
      s2 <= 3'b111;
    end else begin
      s1 <= {cap_hi_in, low_amp_in, pol_pos_in};
      s2 <= s1;
    end
  end

  wire boundary = pwm_in & ~pwm_prev;
  wire cap_n = boundary ? s2[2] : act_cap;
  wire low_n = boundary ? s2[1] : act_low;
  wire pol_n = boundary ? s2[0] : act_pol;

  wire a_chops = low_n ? cap_n : ~cap_n;
  wire hold    = ~low_n;
  wire a_n     = a_chops ? pwm_in : hold;
  wire b_n     = a_chops ? hold : pwm_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_prev <= 1'b0;
      act_cap  <= 1'b1;
      act_low  <= 1'b1;
      act_pol  <= 1'b1;
      mode_pol <= 1'b1;
      buck_a   <= 1'b0;
      buck_b   <= 1'b0;
    end else begin
      pwm_prev <= pwm_in;
      act_cap  <= cap_n;
      act_low  <= low_n;
      act_pol  <= pol_n;
      mode_pol <= pol_n;
      buck_a   <= a_n;
      buck_b   <= b_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dead_q <= 1'b1;
      cnt    <= '0;
      br_pol <= 1'b1;
    end else if (!dead_q && br_pol != pol_n) begin
      dead_q <= 1'b1;
      cnt    <= dead_cycles;
    end else if (dead_q) begin
      if (cnt == '0) begin
        dead_q <= 1'b0;
        br_pol <= pol_n;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign brg_pos_a = ~dead_q & br_pol;
  assign brg_pos_b = ~dead_q & br_pol;
  assign brg_neg_a = ~dead_q & ~br_pol;
  assign brg_neg_b = ~dead_q & ~br_pol;

  wire [1:0] base = ( buck_a & ~buck_b) ? 2'd0 :
                    (~buck_a &  buck_b) ? 2'd1 :
                    (~buck_a & ~buck_b) ? 2'd2 : 2'd3;
  assign mode_code = {~mode_pol, base};

endmodule

// File: rtl/five_lvl_gate_sel_chk.sv
module five_lvl_gate_sel_chk (
  input logic       clk,
  input logic       rst,
  input logic       buck_a,
  input logic       buck_b,
  input logic       brg_pos_a,
  input logic       brg_pos_b,
  input logic       brg_neg_a,
  input logic       brg_neg_b,
  input logic [2:0] mode_code
);
  // R1
  reset_off_chk: assert property (@(posedge clk)
    rst |=> !(buck_a | buck_b | brg_pos_a | brg_pos_b | brg_neg_a | brg_neg_b));

  // R10
  no_shoot_chk: assert property (@(posedge clk) disable iff (rst)
    !((brg_pos_a | brg_pos_b) & (brg_neg_a | brg_neg_b)));

  // R7
  pos_dead_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(brg_pos_a) |-> !$past(brg_neg_a) && !$past(brg_neg_b));

  // R7
  neg_dead_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(brg_neg_a) |-> !$past(brg_pos_a) && !$past(brg_pos_b));

  // R9
  mode_pos_chk: assert property (@(posedge clk) disable iff (rst)
    brg_pos_a |-> mode_code[2] == 1'b0);

  // R9
  mode_neg_chk: assert property (@(posedge clk) disable iff (rst)
    brg_neg_a |-> mode_code[2] == 1'b1);
endmodule

bind five_lvl_gate_sel five_lvl_gate_sel_chk u_chk (
  .clk(clk), .rst(rst), .buck_a(buck_a), .buck_b(buck_b),
  .brg_pos_a(brg_pos_a), .brg_pos_b(brg_pos_b),
  .brg_neg_a(brg_neg_a), .brg_neg_b(brg_neg_b), .mode_code(mode_code)
);

// File: tb/five_lvl_gate_sel_bench.sv
module five_lvl_gate_sel_bench;
  localparam int DT_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwm_in = 1'b0, cap_hi_in = 1'b1, low_amp_in = 1'b1, pol_pos_in = 1'b1;
  logic [DT_W-1:0] dead_cycles = 8'd5;
  logic buck_a, buck_b, brg_pos_a, brg_pos_b, brg_neg_a, brg_neg_b;
  logic [2:0] mode_code;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  five_lvl_gate_sel #(.DT_W(DT_W)) u_five_lvl_gate_sel (
    .clk(clk), .rst(rst), .pwm_in(pwm_in), .cap_hi_in(cap_hi_in),
    .low_amp_in(low_amp_in), .pol_pos_in(pol_pos_in), .dead_cycles(dead_cycles),
    .buck_a(buck_a), .buck_b(buck_b), .brg_pos_a(brg_pos_a), .brg_pos_b(brg_pos_b),
    .brg_neg_a(brg_neg_a), .brg_neg_b(brg_neg_b), .mode_code(mode_code));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int bridge();
    return {brg_pos_a, brg_pos_b, brg_neg_a, brg_neg_b};
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic drive_pwm(input logic v);
    @(negedge clk); pwm_in = v;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) tick();
    chk("R1 gates", {buck_a, buck_b, bridge()}, 0);
    chk("R1 mode", mode_code, 2);
    @(negedge clk); rst = 1'b0;
  endtask

  // expects: a_chop selects buck_a as chopper, hold is level of idle switch
  task automatic t_region(input string tag, input logic lo, input logic cap,
                          input logic pol, input logic a_chop, input logic hold);
    @(negedge clk);
    low_amp_in = lo; cap_hi_in = cap; pol_pos_in = pol;
    repeat (4) drive_pwm(1'b0);
    drive_pwm(1'b1); drive_pwm(1'b1);
    repeat (10) drive_pwm(1'b0);
    for (int ph = 1; ph >= 0; ph--) begin
      drive_pwm(ph[0]);
      tick();
      chk({tag, " buck_a"}, buck_a, a_chop ? ph : int'(hold));
      chk({tag, " buck_b"}, buck_b, a_chop ? int'(hold) : ph);
      chk({tag, " mode"}, mode_code,
          (pol ? 0 : 4) + (({buck_a, buck_b} == 2'b10) ? 0 :
                           ({buck_a, buck_b} == 2'b01) ? 1 :
                           ({buck_a, buck_b} == 2'b00) ? 2 : 3));
      chk("R6 bridge", bridge(), pol ? 4'b1100 : 4'b0011);
    end
  endtask

  // R8: new setting applied mid-period waits for next rising pwm edge
  task automatic t_defer();
    t_region("R2", 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    drive_pwm(1'b1);
    low_amp_in = 1'b0;
    repeat (4) begin
      tick();
      chk("R8 hold high a", buck_a, 1);
      chk("R8 hold high b", buck_b, 0);
    end
    drive_pwm(1'b0);
    repeat (3) begin
      tick();
      chk("R8 hold low a", buck_a, 0);
      chk("R8 hold low b", buck_b, 0);
    end
    drive_pwm(1'b1);
    tick();
    chk("R8 switch a", buck_a, 1);
    chk("R8 switch b", buck_b, 1);
    chk("R9 both on", mode_code, 3);
    drive_pwm(1'b0);
    tick();
    chk("R4 a held", buck_a, 1);
    chk("R4 b chops", buck_b, 0);
  endtask

  task automatic t_dead(input logic to_pos, input int dt);
    @(negedge clk);
    dead_cycles = dt[DT_W-1:0];
    pol_pos_in = to_pos;
    pwm_in = 1'b0;
    repeat (4) begin
      tick();
      chk("R8 pol deferred", bridge(), to_pos ? 4'b0011 : 4'b1100);
    end
    drive_pwm(1'b1);
    for (int i = 0; i <= dt; i++) begin
      tick();
      chk("R7 dead off", bridge(), 0);
      chk("R9 mode half", mode_code[2], to_pos ? 0 : 1);
    end
    tick();
    chk("R7 new diagonal", bridge(), to_pos ? 4'b1100 : 4'b0011);
    chk("R10 no overlap", (brg_pos_a | brg_pos_b) & (brg_neg_a | brg_neg_b), 0);
    drive_pwm(1'b0);
  endtask

  initial begin
    t_reset();
    t_region("R2", 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    t_region("R3", 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    t_region("R4", 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    t_region("R5", 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    t_defer();
    t_dead(1'b0, 5);
    t_region("R5", 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    t_region("R3", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    t_dead(1'b1, 0);
    t_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule